// File: doc/BRIEF.md
# Operator Configuration Manager

This controller sits beside one reconfigurable compute operator. It follows the schedule of operation IDs given to that operator. As soon as an operation reports completion and the next ID is resolved, it starts loading the configuration for that next operation. It does this only when the next ID differs from the one already loaded, so the loading overlaps with whatever else runs in the meantime. The operator's compute enable stays low until the configuration is in place. The operator's current state is always visible on a small status output.

A single parameter chooses between two variants. In the selectable variant, the operator holds every parameter set internally, and a new configuration means presenting a new select value with no waiting. In the loader variant, a request/acknowledge pair goes to an external loader, and the manager waits for that loader. A scheduled ID may depend on a runtime condition. In that case the manager resolves it, and issues any request, only once the condition value arrives.

Top module: `opcfg_manager`

## Requirements
- R1: After reset the status is IDLE, `op_en`, `ld_req` and `cfg_sel` are 0, and no configuration counts as loaded. The first resolved operation therefore always needs configuring, even when its ID is 0.
- R2: `op_state` encodes IDLE=0, RUN=1, WAIT_NEXT=2, CONFIG=3, READY=4.
- R3: In IDLE or WAIT_NEXT the schedule resolves on a cycle where `nxt_valid`=1 and either `nxt_cond`=0 (ID is `nxt_op0`) or `cond_valid`=1 (ID is `nxt_op1` when `cond_sel`=1, else `nxt_op0`). While a conditional entry waits for `cond_valid`, the state does not change and no request is raised.
- R4: A request for a new ID is issued at the clock edge where the schedule resolves, without waiting for `op_start`.
- R5: When the resolved ID equals the loaded one, the state goes to READY at that edge and no request is raised.
- R6: With DYNAMIC=0, a new ID appears on `cfg_sel` at the resolving edge, the state goes straight to READY, and `ld_req` stays 0.
- R7: With DYNAMIC=1, a new ID moves the state to CONFIG and sets `ld_req`=1 with `ld_op` equal to that ID. Both hold until the edge where `ld_ack`=1 is sampled. `ld_ack` at any other time is ignored. `cfg_sel` stays 0 in this variant.
- R8: `op_en` is 1 only in RUN. It rises at the edge after `op_start` is sampled in READY.
- R9: An `op_start` sampled in IDLE, WAIT_NEXT or CONFIG is remembered. At the acknowledging edge in CONFIG the state then enters RUN with `op_en`=1. From READY it enters RUN at the next edge.
- R10: An `op_start` sampled in RUN has no effect and is not remembered.
- R11: `op_done` sampled in RUN clears `op_en` and moves the state to WAIT_NEXT at that edge. `op_done` in any other state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_valid | input | 1 | Schedule entry present |
| nxt_cond | input | 1 | Entry depends on a condition |
| nxt_op0 | input | OP_W | ID taken when unconditional or condition is 0 |
| nxt_op1 | input | OP_W | ID taken when condition is 1 |
| cond_valid | input | 1 | Condition value known |
| cond_sel | input | 1 | Condition value |
| op_start | input | 1 | Operator start request |
| op_done | input | 1 | Operator completion |
| ld_ack | input | 1 | Loader finished the requested configuration |
| op_en | output | 1 | Compute enable |
| op_state | output | 3 | Status code |
| cfg_sel | output | OP_W | Parameter-set select (DYNAMIC=0) |
| ld_req | output | 1 | Load request (DYNAMIC=1) |
| ld_op | output | OP_W | ID to load |

## Verification
The bench builds two instances at once: DYNAMIC=1 and DYNAMIC=0, both with OP_W=3. This exercises the loader handshake and the zero-latency select path under the same operation sequences. With only eight IDs, repeated IDs and ID 0 right after reset are easy to schedule, so both the skipped-request path and the no-config-after-reset path are reached. A loader latency of three cycles leaves a CONFIG window long enough to land a start pulse inside it and to see conditions resolve late.

// File: rtl/opcfg_pkg.sv
package opcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_WAIT = 3'd2,
    ST_CFG  = 3'd3,
    ST_RDY  = 3'd4
  } opst_e;
endpackage

// File: rtl/opcfg_select.sv
module opcfg_select #(
  parameter int OP_W = 4
) (
  input  logic            nxt_valid,
  input  logic            nxt_cond,
  input  logic [OP_W-1:0] nxt_op0,
  input  logic [OP_W-1:0] nxt_op1,
  input  logic            cond_valid,
  input  logic            cond_sel,
  input  logic            have_cfg,
  input  logic [OP_W-1:0] cur_op,
  output logic            resolved,
  output logic [OP_W-1:0] res_op,
  output logic            hit
);
  always_comb begin
    resolved = nxt_valid & (~nxt_cond | cond_valid);
    res_op   = (nxt_cond & cond_sel) ? nxt_op1 : nxt_op0;
    hit      = have_cfg & (res_op == cur_op);
  end
endmodule

// File: rtl/opcfg_store.sv
module opcfg_store #(
  parameter int OP_W    = 4,
  parameter bit DYNAMIC = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [OP_W-1:0] issue_op,
  input  logic            ld_ack,
  output logic            have_cfg,
  output logic [OP_W-1:0] cur_op,
  output logic [OP_W-1:0] cfg_sel,
  output logic            ld_req,
  output logic [OP_W-1:0] ld_op,
  output logic            cfg_done
);
  generate
    if (DYNAMIC) begin : g_loader
      always_ff @(posedge clk) begin
        if (rst) begin
          have_cfg <= 1'b0;
          cur_op   <= '0;
          ld_req   <= 1'b0;
          ld_op    <= '0;
        end else if (issue) begin
          ld_req <= 1'b1;
          ld_op  <= issue_op;
        end else if (ld_req && ld_ack) begin
          ld_req   <= 1'b0;
          cur_op   <= ld_op;
          have_cfg <= 1'b1;
        end
      end
      assign cfg_sel  = '0;
      assign cfg_done = ld_req & ld_ack;

      // R7
      req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !ld_ack) |=> (ld_req && $stable(ld_op)));
    end else begin : g_select
      always_ff @(posedge clk) begin
        if (rst) begin
          have_cfg <= 1'b0;
          cur_op   <= '0;
        end else if (issue) begin
          have_cfg <= 1'b1;
          cur_op   <= issue_op;
        end
      end
      assign cfg_sel  = cur_op;
      assign ld_req   = 1'b0;
      assign ld_op    = '0;
      assign cfg_done = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/opcfg_fsm.sv
module opcfg_fsm
  import opcfg_pkg::*;
#(
  parameter bit DYNAMIC = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       resolved,
  input  logic       hit,
  input  logic       op_start,
  input  logic       op_done,
  input  logic       cfg_done,
  output logic       issue,
  output logic [2:0] state,
  output logic       op_en
);
  opst_e st;
  logic  pend;

  assign state = st;
  assign issue = ((st == ST_IDLE) || (st == ST_WAIT)) && resolved && !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      pend  <= 1'b0;
      op_en <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE, ST_WAIT: begin
          if (op_start) pend <= 1'b1;
          if (resolved) st <= (hit || !DYNAMIC) ? ST_RDY : ST_CFG;
        end
        ST_CFG: begin
          if (cfg_done) begin
            if (pend || op_start) begin
              st    <= ST_RUN;
              op_en <= 1'b1;
              pend  <= 1'b0;
            end else begin
              st <= ST_RDY;
            end
          end else if (op_start) begin
            pend <= 1'b1;
          end
        end
        ST_RDY: begin
          if (pend || op_start) begin
            st    <= ST_RUN;
            op_en <= 1'b1;
            pend  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (op_done) begin
            st    <= ST_WAIT;
            op_en <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  en_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(op_en) |-> ($past(op_start) || $past(pend)));

  // R11
  done_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && op_done) |=> (st == ST_WAIT && !op_en));

  // R8
  en_run_chk: assert property (@(posedge clk) disable iff (rst)
    op_en |-> (st == ST_RUN));
endmodule

// File: rtl/opcfg_manager.sv
module opcfg_manager
  import opcfg_pkg::*;
#(
  parameter int OP_W    = 4,
  parameter bit DYNAMIC = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            nxt_valid,
  input  logic            nxt_cond,
  input  logic [OP_W-1:0] nxt_op0,
  input  logic [OP_W-1:0] nxt_op1,
  input  logic            cond_valid,
  input  logic            cond_sel,
  input  logic            op_start,
  input  logic            op_done,
  input  logic            ld_ack,
  output logic            op_en,
  output logic [2:0]      op_state,
  output logic [OP_W-1:0] cfg_sel,
  output logic            ld_req,
  output logic [OP_W-1:0] ld_op
);
  logic            have_cfg, resolved, hit, issue, cfg_done;
  logic [OP_W-1:0] cur_op, res_op;

  opcfg_select #(.OP_W(OP_W)) u_sel (
    .nxt_valid(nxt_valid), .nxt_cond(nxt_cond), .nxt_op0(nxt_op0),
    .nxt_op1(nxt_op1), .cond_valid(cond_valid), .cond_sel(cond_sel),
    .have_cfg(have_cfg), .cur_op(cur_op), .resolved(resolved),
    .res_op(res_op), .hit(hit));

  opcfg_store #(.OP_W(OP_W), .DYNAMIC(DYNAMIC)) u_store (
    .clk(clk), .rst(rst), .issue(issue), .issue_op(res_op), .ld_ack(ld_ack),
    .have_cfg(have_cfg), .cur_op(cur_op), .cfg_sel(cfg_sel),
    .ld_req(ld_req), .ld_op(ld_op), .cfg_done(cfg_done));

  opcfg_fsm #(.DYNAMIC(DYNAMIC)) u_fsm (
    .clk(clk), .rst(rst), .resolved(resolved), .hit(hit),
    .op_start(op_start), .op_done(op_done), .cfg_done(cfg_done),
    .issue(issue), .state(op_state), .op_en(op_en));

  // R5
  hit_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_state == ST_IDLE || op_state == ST_WAIT) && resolved && hit)
      |=> (op_state == ST_RDY && !ld_req));

  // R3
  cond_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_state == ST_WAIT) && nxt_valid && nxt_cond && !cond_valid)
      |=> (op_state == ST_WAIT && !ld_req));

  generate
    if (!DYNAMIC) begin : g_sel_chk
      // R6
      sel_apply_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_state == ST_IDLE || op_state == ST_WAIT) && resolved && !hit)
          |=> (op_state == ST_RDY && cfg_sel == $past(res_op)));
    end else begin : g_ld_chk
      // R4
      prefetch_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_state == ST_IDLE || op_state == ST_WAIT) && resolved && !hit)
          |=> (ld_req && op_state == ST_CFG));
    end
  endgenerate
endmodule

// File: tb/test_opcfg_manager.sv
module test_opcfg_manager;
  localparam int OP_W = 3;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic nv[2], nc[2], cv[2], cs[2], st[2], dn[2], ack[2];
  logic [OP_W-1:0] o0[2], o1[2];
  logic en_o[2], req_o[2];
  logic [2:0] state_o[2];
  logic [OP_W-1:0] sel_o[2], ldop_o[2];

  int vectors = 0, fails = 0;
  bit done_flag = 0;

  opcfg_manager #(.OP_W(OP_W), .DYNAMIC(1'b1)) i_opcfg_manager (
    .clk(clk), .rst(rst), .nxt_valid(nv[0]), .nxt_cond(nc[0]),
    .nxt_op0(o0[0]), .nxt_op1(o1[0]), .cond_valid(cv[0]), .cond_sel(cs[0]),
    .op_start(st[0]), .op_done(dn[0]), .ld_ack(ack[0]), .op_en(en_o[0]),
    .op_state(state_o[0]), .cfg_sel(sel_o[0]), .ld_req(req_o[0]),
    .ld_op(ldop_o[0]));

  opcfg_manager #(.OP_W(OP_W), .DYNAMIC(1'b0)) i_opcfg_manager_sel (
    .clk(clk), .rst(rst), .nxt_valid(nv[1]), .nxt_cond(nc[1]),
    .nxt_op0(o0[1]), .nxt_op1(o1[1]), .cond_valid(cv[1]), .cond_sel(cs[1]),
    .op_start(st[1]), .op_done(dn[1]), .ld_ack(ack[1]), .op_en(en_o[1]),
    .op_state(state_o[1]), .cfg_sel(sel_o[1]), .ld_req(req_o[1]),
    .ld_op(ldop_o[1]));

  // behavioural reference, one slot per instance (0: loader, 1: select)
  int m_st[2], m_en[2], m_sel[2], m_req[2], m_ldop[2], m_have[2], m_cur[2], m_pend[2];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_st[k] = 0; m_en[k] = 0; m_sel[k] = 0; m_req[k] = 0;
        m_ldop[k] = 0; m_have[k] = 0; m_cur[k] = 0; m_pend[k] = 0;
      end else begin
        bit res, hit;
        int op;
        res = nv[k] && (!nc[k] || cv[k]);
        op  = (nc[k] && cs[k]) ? int'(o1[k]) : int'(o0[k]);
        hit = (m_have[k] != 0) && (op == m_cur[k]);
        case (m_st[k])
          0, 2: begin
            if (st[k]) m_pend[k] = 1;
            if (res) begin
              if (hit) m_st[k] = 4;
              else if (k == 0) begin m_req[k] = 1; m_ldop[k] = op; m_st[k] = 3; end
              else begin m_cur[k] = op; m_have[k] = 1; m_sel[k] = op; m_st[k] = 4; end
            end
          end
          3: begin
            if (ack[k]) begin
              m_req[k] = 0; m_cur[k] = m_ldop[k]; m_have[k] = 1;
              if (m_pend[k] != 0 || st[k]) begin m_st[k] = 1; m_en[k] = 1; m_pend[k] = 0; end
              else m_st[k] = 4;
            end else if (st[k]) m_pend[k] = 1;
          end
          4: if (m_pend[k] != 0 || st[k]) begin m_st[k] = 1; m_en[k] = 1; m_pend[k] = 0; end
          1: if (dn[k]) begin m_st[k] = 2; m_en[k] = 0; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 2; k++) begin
        chk(int'(state_o[k]) == m_st[k], "R2 state", int'(state_o[k]), m_st[k]);
        chk(int'(en_o[k]) == m_en[k], "R8 op_en", int'(en_o[k]), m_en[k]);
        chk(int'(sel_o[k]) == m_sel[k], "R6 cfg_sel", int'(sel_o[k]), m_sel[k]);
        chk(int'(req_o[k]) == m_req[k], "R7 ld_req", int'(req_o[k]), m_req[k]);
        chk(int'(ldop_o[k]) == m_ldop[k], "R7 ld_op", int'(ldop_o[k]), m_ldop[k]);
      end
    end
  end

  // loader responder for the loader instance
  initial begin
    ack[0] = 1'b0;
    forever begin
      @(negedge clk);
      if (req_o[0] && !ack[0]) begin
        repeat (LAT - 1) @(negedge clk);
        ack[0] = 1'b1;
        @(negedge clk);
        ack[0] = 1'b0;
      end
    end
  end

  // smode: 0 start in READY, 1 start before the schedule, 2 start during CONFIG
  task automatic do_op(input int k, input int a, input int b, input bit c, input bit s,
                       input int cdly, input int smode, input int rlen, input bit exp_hit);
    int exp_op;
    exp_op = (c && s) ? b : a;
    while (!(state_o[k] == 3'd0 || state_o[k] == 3'd2)) @(negedge clk);
    if (smode == 1) begin
      st[k] = 1'b1; @(negedge clk); st[k] = 1'b0;
    end
    nv[k] = 1'b1; o0[k] = OP_W'(a); o1[k] = OP_W'(b); nc[k] = c; cs[k] = s; cv[k] = 1'b0;
    if (c) begin
      for (int i = 0; i < cdly; i++) begin
        @(negedge clk);
        chk((state_o[k] == 3'd0 || state_o[k] == 3'd2) && !req_o[k], "R3 held", int'(state_o[k]), 2);
      end
      cv[k] = 1'b1;
    end
    @(negedge clk);
    nv[k] = 1'b0; cv[k] = 1'b0;
    if (exp_hit)
      chk(state_o[k] == 3'd4 && !req_o[k], "R5 hit", int'(state_o[k]), 4);
    else if (k == 0) begin
      chk(state_o[k] == 3'd3 && req_o[k], "R4 prefetch", int'(state_o[k]), 3);
      chk(int'(ldop_o[k]) == exp_op, "R7 ld_op", int'(ldop_o[k]), exp_op);
    end else
      chk(state_o[k] == 3'd4 && int'(sel_o[k]) == exp_op && !req_o[k], "R6 select",
          int'(sel_o[k]), exp_op);
    if (smode == 2 && state_o[k] == 3'd3) begin
      st[k] = 1'b1; @(negedge clk); st[k] = 1'b0;
      while (state_o[k] == 3'd3) @(negedge clk);
      chk(state_o[k] == 3'd1 && en_o[k], "R9 direct run", int'(state_o[k]), 1);
    end else if (smode != 1) begin
      while (state_o[k] != 3'd4) @(negedge clk);
      dn[k] = 1'b1;
      if (k == 0) ack[0] = 1'b1;   // stray acknowledge
      @(negedge clk);
      dn[k] = 1'b0;
      if (k == 0) ack[0] = 1'b0;
      chk(state_o[k] == 3'd4 && !en_o[k], "R11 done ignored", int'(state_o[k]), 4);
      chk(state_o[k] == 3'd4, "R10 no stale start", int'(state_o[k]), 4);
      chk(!req_o[k], "R7 stray ack", int'(req_o[k]), 0);
      st[k] = 1'b1; @(negedge clk); st[k] = 1'b0;
    end
    while (state_o[k] != 3'd1) @(negedge clk);
    chk(en_o[k], "R8 enable in run", int'(en_o[k]), 1);
    st[k] = 1'b1; @(negedge clk); st[k] = 1'b0;   // ignored start in RUN
    repeat (rlen) @(negedge clk);
    dn[k] = 1'b1; @(negedge clk); dn[k] = 1'b0;
    chk(state_o[k] == 3'd2 && !en_o[k], "R11 done", int'(state_o[k]), 2);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      nv[k] = 0; nc[k] = 0; cv[k] = 0; cs[k] = 0; st[k] = 0; dn[k] = 0;
      o0[k] = '0; o1[k] = '0;
    end
    ack[1] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(state_o[k] == 3'd0 && !en_o[k] && !req_o[k] && sel_o[k] == '0, "R1 reset",
          int'(state_o[k]), 0);
    for (int k = 0; k < 2; k++) begin
      do_op(k, 0, 0, 0, 0, 0, 0, 3, 0);   // R1 first op 0 still configures
      do_op(k, 0, 5, 0, 0, 0, 0, 2, 1);   // R5 repeat
      do_op(k, 5, 2, 1, 1, 3, 0, 2, 0);   // R3 late condition
      do_op(k, 1, 2, 1, 1, 0, 0, 1, 1);   // R3 condition known at once, hit
      do_op(k, 6, 0, 0, 0, 0, 2, 2, 0);   // R9 start in CONFIG
      do_op(k, 3, 0, 0, 0, 0, 1, 1, 0);   // R9 start before schedule
      do_op(k, 3, 1, 0, 0, 0, 1, 1, 1);   // R9 early start with hit
      do_op(k, 7, 4, 1, 0, 2, 2, 4, 0);   // R3 condition 0
    end
    repeat (3) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule